// File: doc/BRIEF.md
# Quarter-Wave Sine and Cosine Generator

The block turns an unsigned phase word into a pair of signed two's-complement amplitudes, one for sine and one for cosine. Only a quarter period of magnitudes is held. The other three quarters come from two changes. Reversing the quarter index produces the falling half of each positive lobe. Negating the magnitude produces the negative half-period.

Each phase code stands for the centre of its step, so code `k` is the angle 2π·(k + 0.5) / 2^PHASE_W. Because of this centring, no code falls on a zero crossing or a peak. It also makes the reversed index an exact bitwise inversion.

The magnitudes are computed while the design elaborates. Each one is the scaled ideal value rounded to the nearest integer, with a full scale of 2^(AMP_W−1) − 1. A register chain of LAT stages follows the lookup. The chain moves only while the clock enable is high and clears on a synchronous, active-high reset. LAT = 0 gives a purely combinational path.

Top module: `qwave_sincos`

## Requirements
- R1: For phase code k, `sin_o` equals round((2^(AMP_W−1) − 1) · sin(2π·(k + 0.5) / 2^PHASE_W)), rounded to the nearest integer, so the error is under half an LSB.
- R2: For phase code k, `cos_o` equals the same rounded expression with cos in place of sin.
- R3: Neither output ever carries the most negative code (−128 for 8 bits). Both stay within ±(2^(AMP_W−1) − 1).
- R4: The sine output is odd over a half period: sin(k + 2^(PHASE_W−1)) = −sin(k). It is mirrored within each half period: sin(2^(PHASE_W−1) − 1 − k) = sin(k).
- R5: While `ce` is held high, a phase presented before a clock edge appears on both outputs exactly LAT edges later.
- R6: At an edge where `ce` is low and `rst` is low, neither output changes, whatever the phase input does.
- R7: At an edge where `rst` is high, every pipeline register clears to zero regardless of `ce`, so both outputs read 0 after that edge (for LAT > 0).
- R8: The cosine for code k equals the sine for code (k + 2^(PHASE_W−2)) mod 2^PHASE_W, and it arrives in the same cycle as the sine for k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset that clears the delay chain |
| ce | input | 1 | Clock enable; the chain advances only when high |
| phase | input | PHASE_W | Unsigned phase code |
| sin_o | output | AMP_W | Signed sine amplitude |
| cos_o | output | AMP_W | Signed cosine amplitude |

## Verification
Reset and clock enable can both be active at the same edge. The design must let reset win even while the enable is low.

The bench provokes this by asserting `rst` during a stretch where `ce` is held low. It then follows the reset with a random enable pattern.

A cycle-accurate reference checks both outputs after every edge. The reference clears on reset independently of the enable and shifts only when enabled. An exhaustive per-code capture then judges the rounding, the symmetries and the quarter-period relation between the two outputs.

// File: rtl/qwave_pkg.sv
package qwave_pkg;

    localparam real QW_PI = 3.14159265358979323846;

    // Power series for sine; converges far below an LSB on [0, pi/2].
    function automatic real qw_series_sin(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n < 14; n++) begin
            term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Magnitude for quarter index idx, sampled at the centre of its step.
    function automatic int qw_entry(input int idx, input int phase_w, input int amp_w);
        real ang;
        real val;
        ang = 2.0 * QW_PI * (real'(idx) + 0.5) / real'(2 ** phase_w);
        val = qw_series_sin(ang) * real'((2 ** (amp_w - 1)) - 1);
        return $rtoi(val + 0.5);
    endfunction

endpackage

// File: rtl/qw_fold.sv
module qw_fold #(
    parameter int PHASE_W = 8
) (
    input  logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-3:0] idx,
    output logic               neg
);
    localparam int IDX_W = PHASE_W - 2;

    logic mirror;

    always_comb begin
        mirror = phase[PHASE_W-2];
        neg    = phase[PHASE_W-1];
        idx    = phase[IDX_W-1:0] ^ {IDX_W{mirror}};
    end
endmodule

// File: rtl/qw_rom.sv
module qw_rom #(
    parameter int PHASE_W = 8,
    parameter int AMP_W   = 8
) (
    input  logic [PHASE_W-3:0] idx,
    output logic [AMP_W-2:0]   mag
);
    localparam int IDX_W = PHASE_W - 2;
    localparam int DEPTH = 1 << IDX_W;
    localparam int MAG_W = AMP_W - 1;

    logic [MAG_W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int V = qwave_pkg::qw_entry(g, PHASE_W, AMP_W);
        assign tbl[g] = V[MAG_W-1:0];
    end

    assign mag = tbl[idx];
endmodule

// File: rtl/qw_delay.sv
module qw_delay #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (STAGES == 0) begin : g_pass
        logic unused_ctl;
        assign unused_ctl = ^{clk, rst, ce};
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] r [STAGES];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < STAGES; i++) r[i] <= '0;
            end else if (ce) begin
                r[0] <= d;
                for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
        end
        assign q = r[STAGES-1];
    end
endmodule

// File: rtl/qwave_sincos.sv
module qwave_sincos #(
    parameter int PHASE_W = 8,
    parameter int AMP_W   = 8,
    parameter int LAT     = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ce,
    input  logic        [PHASE_W-1:0] phase,
    output logic signed [AMP_W-1:0]   sin_o,
    output logic signed [AMP_W-1:0]   cos_o
);
    localparam int IDX_W = PHASE_W - 2;
    localparam int MAG_W = AMP_W - 1;
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << IDX_W;

    logic signed [AMP_W-1:0] amp [2];
    logic [2*AMP_W-1:0]      pair_d;
    logic [2*AMP_W-1:0]      pair_q;

    // channel 0 = sine, channel 1 = cosine (phase advanced a quarter)
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        localparam logic [PHASE_W-1:0] OFFS = (ch == 0) ? '0 : QUARTER;

        logic [PHASE_W-1:0] ph;
        logic [IDX_W-1:0]   idx;
        logic               neg;
        logic [MAG_W-1:0]   mag;
        logic signed [AMP_W-1:0] ext;

        assign ph = phase + OFFS;

        qw_fold #(.PHASE_W(PHASE_W)) i_fold (
            .phase (ph),
            .idx   (idx),
            .neg   (neg)
        );

        qw_rom #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) i_rom (
            .idx (idx),
            .mag (mag)
        );

        always_comb begin
            ext     = $signed({1'b0, mag});
            amp[ch] = neg ? -ext : ext;
        end
    end

    assign pair_d = {amp[0], amp[1]};

    qw_delay #(.W(2 * AMP_W), .STAGES(LAT)) i_delay (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .d   (pair_d),
        .q   (pair_q)
    );

    assign sin_o = $signed(pair_q[2*AMP_W-1:AMP_W]);
    assign cos_o = $signed(pair_q[AMP_W-1:0]);
endmodule

// File: rtl/qwave_sincos_chk.sv
module qwave_sincos_chk #(
    parameter int AMP_W = 8,
    parameter int LAT   = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ce,
    input logic signed [AMP_W-1:0] sin_o,
    input logic signed [AMP_W-1:0] cos_o
);
    localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    assert_no_overflow_sin_R3: assert property (
        @(posedge clk) disable iff (rst) sin_o != MOST_NEG);

    assert_no_overflow_cos_R3: assert property (
        @(posedge clk) disable iff (rst) cos_o != MOST_NEG);

    if (LAT > 0) begin : g_seq
        assert_hold_when_idle_R6: assert property (
            @(posedge clk) disable iff (rst)
            (!ce) |=> ($stable(sin_o) && $stable(cos_o)));

        assert_reset_clears_R7: assert property (
            @(posedge clk) rst |=> (sin_o == '0 && cos_o == '0));
    end
endmodule

bind qwave_sincos qwave_sincos_chk #(.AMP_W(AMP_W), .LAT(LAT)) i_chk (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .sin_o (sin_o),
    .cos_o (cos_o)
);

// File: tb/test_qwave_sincos.sv
module test_qwave_sincos;
    localparam int PHASE_W = 8;
    localparam int AMP_W   = 8;
    localparam int LAT     = 2;
    localparam int N       = 1 << PHASE_W;
    localparam real PI     = 3.14159265358979323846;
    localparam real SCALE  = real'((1 << (AMP_W - 1)) - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b0;
    logic [PHASE_W-1:0] phase = '0;
    logic signed [AMP_W-1:0] sin_o;
    logic signed [AMP_W-1:0] cos_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int ms [LAT+1];
    int mc [LAT+1];
    int cap_s [N];
    int cap_c [N];

    always #2 clk = ~clk;

    qwave_sincos #(.PHASE_W(PHASE_W), .AMP_W(AMP_W), .LAT(LAT)) i_qwave_sincos (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .phase (phase),
        .sin_o (sin_o),
        .cos_o (cos_o)
    );

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic int ref_sin(input int k);
        return rnd(SCALE * $sin(2.0 * PI * (real'(k) + 0.5) / real'(N)));
    endfunction

    function automatic int ref_cos(input int k);
        return rnd(SCALE * $cos(2.0 * PI * (real'(k) + 0.5) / real'(N)));
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, model the rising edge, sample after it.
    task automatic step(input logic r, input logic e, input int ph);
        string tag;
        int es;
        int ec;
        @(negedge clk);
        rst   = r;
        ce    = e;
        phase = ph[PHASE_W-1:0];
        @(posedge clk);
        if (r) begin
            for (int i = 0; i <= LAT; i++) begin ms[i] = 0; mc[i] = 0; end
        end else if (e) begin
            for (int i = LAT; i > 0; i--) begin ms[i] = ms[i-1]; mc[i] = mc[i-1]; end
            ms[0] = ref_sin(ph % N);
            mc[0] = ref_cos(ph % N);
        end
        #1;
        if (LAT == 0) begin es = ref_sin(ph % N); ec = ref_cos(ph % N); end
        else begin es = ms[LAT-1]; ec = mc[LAT-1]; end
        tag = r ? "R7" : (!e ? "R6" : "R5");
        check(tag, "sin_o", int'(sin_o), es);
        check(tag, "cos_o", int'(cos_o), ec);
    endtask

    initial begin
        for (int i = 0; i <= LAT; i++) begin ms[i] = 0; mc[i] = 0; end
        // reset with enable low: R7
        step(1'b1, 1'b0, 0);
        step(1'b1, 1'b0, 77);
        step(1'b0, 1'b0, 13);
        // continuous ramp, two full periods: R5
        for (int k = 0; k < 2 * N; k++) step(1'b0, 1'b1, k);
        // enable low while phase changes: R6
        for (int k = 0; k < 10; k++) step(1'b0, 1'b0, 3 * k + 5);
        // reset while enable low mid-stream: R7
        step(1'b1, 1'b0, 200);
        step(1'b0, 1'b1, 40);
        // random enable and phase, occasional reset
        for (int k = 0; k < 600; k++) begin
            step(($urandom % 50) == 0, ($urandom % 4) != 0, int'($urandom % N));
        end
        // exhaustive per-code capture with the phase held
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j <= LAT; j++) step(1'b0, 1'b1, k);
            cap_s[k] = int'(sin_o);
            cap_c[k] = int'(cos_o);
        end
        for (int k = 0; k < N; k++) begin
            check("R1", "sin value", cap_s[k], ref_sin(k));
            check("R2", "cos value", cap_c[k], ref_cos(k));
            checks++;
            if (cap_s[k] < -int'(SCALE) || cap_c[k] < -int'(SCALE) ||
                cap_s[k] > int'(SCALE) || cap_c[k] > int'(SCALE)) begin
                errors++;
                $display("FAIL R3 range actual %0d/%0d expected within +-%0d",
                         cap_s[k], cap_c[k], int'(SCALE));
            end
            check("R4", "odd half period", cap_s[(k + N / 2) % N], -cap_s[k]);
            if (k < N / 2) check("R4", "mirror", cap_s[N / 2 - 1 - k], cap_s[k]);
            check("R8", "quarter shift", cap_c[k], cap_s[(k + N / 4) % N]);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule